// File: doc/BRIEF.md
# LED Breathing Pattern Sequencer

This block is the timing engine of one LED breathing pattern. A start key written to its update input latches a working copy of the whole pattern setup and starts the sequence: one start delay, then pulses made of rise, hold and fall phases. Pulses inside one colour pass are separated by an inter-pulse gap, and each pattern pass closes with an off phase. Every phase length comes from a 4-bit duration code, and the phase counter advances only on a slow time-base tick.

Three loops are nested. The innermost repeats pulses within a colour pass. The middle one walks the enabled colours in ascending order and repeats each colour as its count asks. The outer one repeats the whole pattern. When the sequence completes, the block idles, parks dark, or parks lit at the end of the final hold phase. It can also raise a one-cycle request naming the pattern to chain to.

The outputs are a target level, a ramp direction, the phase and a status word. A downstream current stage applies the level, with any gamma shaping it performs.

Top module: `breath_seq`

## Requirements
- R1: A write of exactly 0xC5 on the update input starts the pattern from the start phase (phase 000, run bit set), provided at least one colour is enabled. Any other value, or a write with no colour enabled, leaves every output unchanged.
- R2: Duration code n (0..15) selects 3, 13, 26, 38, 51, 77, 104, 160, 210, 260, 310, 420, 520, 620, 730 or 830 hundredths of a second. This is converted to a count of time-base ticks, rounded to the nearest whole tick with a minimum of 1. A phase lasts exactly that many ticks, and the phase never changes on a cycle without a tick. Codes are packed 4 bits per phase with the start phase in bits 3:0, ordered by phase code.
- R3: The phase field reads start=000, rise=001, hold=010, fall=011, gap=100, off=101. The start phase runs once per start. After it, every pulse runs rise, hold and fall, followed by either gap or off.
- R4: The 4-bit pulse count sets how many pulses one colour pass runs (0 = endless). Consecutive pulses are separated by the gap phase.
- R5: Colours run in ascending index order and skip disabled ones. Each colour pass repeats according to its 2-bit count (00 endless, 01..11 = 1..3 times). The last pulse of the last enabled colour is followed by the off phase instead of the gap.
- R6: The 8-bit pattern loop field counts its low 7 bits, multiplied by 16 when bit 7 is set. A zero count means endless. Each new loop restarts at the first enabled colour without a start phase.
- R7: The level output equals the active colour's 8-bit level during rise, hold and fall, and is 0 otherwise. The ramp output is 01 during rise and 10 during fall, otherwise 00. The status word holds the run bit in bit 7, colour 3..1 as a one-hot in bits 6:4 (during rise to off, or while parked lit), 0 in bit 3, and the phase in bits 2:0.
- R8: At completion, what happens depends on the hold settings. With hold disabled, the block returns to idle (phase 000, level 0). With hold enabled and hold-type 0, it parks at the end of the off phase (phase 101, level 0). With hold enabled and hold-type 1, it stops at the end of the hold phase of the final pulse (phase 010, level held at the colour level). In every case the run bit is 0.
- R9: At completion, a next field of 01 or 10 gives a one-cycle chain pulse with that value on the chain-select output. Values 00 and 11 give no pulse.
- R10: A start key during a run restarts from the start phase with every loop counter reloaded. Setup inputs are captured only at start, so changes made during a run have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base tick (one tick per TICK_US microseconds) |
| upd_we_i | input | 1 | Update register write strobe |
| upd_data_i | input | 8 | Update register write value |
| cfg_dur_i | input | 24 | Six 4-bit duration codes, indexed by phase code |
| cfg_lvl_i | input | NCOL*LVL_W | Per-colour level, colour 1 lowest |
| cfg_cen_i | input | NCOL | Per-colour enable |
| cfg_crep_i | input | NCOL*CREP_W | Per-colour repeat count |
| cfg_pulses_i | input | PULSE_W | Pulses per colour pass |
| cfg_loops_i | input | LOOP_W | Pattern loop field |
| cfg_hold_en_i | input | 1 | Hold at completion enable |
| cfg_hold_on_i | input | 1 | Hold type: 1 lit after hold, 0 dark after off |
| cfg_next_i | input | 2 | Completion action |
| lvl_o | output | LVL_W | Target level |
| ramp_o | output | 2 | Ramp direction (01 rise, 10 fall) |
| phase_o | output | 3 | Current phase |
| state_o | output | 8 | Status word |
| chain_o | output | 1 | One-cycle chain request |
| chain_sel_o | output | 2 | Next field captured at completion |

## Verification
The checker watches every cycle for a legal phase code and legal phase successions. It also checks that phases move only on ticks, that levels stay dark outside the lit phases, that the ramp and colour bits are one-hot or clear, that a parked-lit level is stable, and that chain pulses last one cycle. Exact phase lengths, loop and repeat counts, colour skipping, the final hold choice and the capture of setup at start depend on counting across many phases. Only the bench's cycle-by-cycle reference model, driven through its scenarios, can show those.

// File: rtl/breath_pkg.sv
package breath_pkg;

   typedef enum logic [2:0] {
      PH_START = 3'd0,
      PH_RISE  = 3'd1,
      PH_HOLD  = 3'd2,
      PH_FALL  = 3'd3,
      PH_GAP   = 3'd4,
      PH_OFF   = 3'd5
   } phase_e;

   typedef enum logic [1:0] {
      MD_IDLE     = 2'd0,
      MD_RUN      = 2'd1,
      MD_PARK_LIT = 2'd2,
      MD_PARK_DRK = 2'd3
   } mode_e;

   localparam logic [7:0] START_KEY  = 8'hC5;
   localparam int         NUM_PHASES = 6;
   localparam int         CODE_W     = 4;

   // duration of a code in hundredths of a second
   function automatic int unsigned code_cs(input logic [3:0] c);
      case (c)
         4'd0:  return 3;
         4'd1:  return 13;
         4'd2:  return 26;
         4'd3:  return 38;
         4'd4:  return 51;
         4'd5:  return 77;
         4'd6:  return 104;
         4'd7:  return 160;
         4'd8:  return 210;
         4'd9:  return 260;
         4'd10: return 310;
         4'd11: return 420;
         4'd12: return 520;
         4'd13: return 620;
         4'd14: return 730;
         default: return 830;
      endcase
   endfunction

   // nearest whole number of ticks, at least one
   function automatic int unsigned code_ticks(input logic [3:0] c, input int unsigned tick_us);
      longint unsigned us;
      longint unsigned t;
      us = longint'(code_cs(c)) * 64'd10000;
      t  = (us + longint'(tick_us / 2)) / longint'(tick_us);
      if (t == 0) t = 1;
      return int'(t);
   endfunction

endpackage

// File: rtl/breath_dur_sel.sv
module breath_dur_sel #(
   parameter int unsigned TICK_US = 10000,
   parameter int          DUR_W   = 10
) (
   input  logic [3:0]       code_i,
   output logic [DUR_W-1:0] ticks_m1_o
);
   localparam int unsigned MAX_T = breath_pkg::code_ticks(4'hF, TICK_US);

   if (DUR_W < $clog2(MAX_T + 1)) begin : g_bad_w
      $error("breath_dur_sel: DUR_W too narrow for longest code");
   end

   logic [DUR_W-1:0] tbl [16];

   for (genvar g = 0; g < 16; g++) begin : g_tbl
      localparam int unsigned T = breath_pkg::code_ticks(4'(g), TICK_US);
      assign tbl[g] = DUR_W'(T - 1);
   end

   assign ticks_m1_o = tbl[code_i];
endmodule

// File: rtl/breath_loop_ctr.sv
module breath_loop_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic [W-1:0] cnt_o,
   output logic         last_o
);
   // value 0 = endless: never decremented, never last
   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt_o <= '0;
      else if (load_i)                 cnt_o <= load_val_i;
      else if (dec_i && cnt_o > W'(1)) cnt_o <= cnt_o - W'(1);
   end

   assign last_o = (cnt_o == W'(1));
endmodule

// File: rtl/breath_col_pick.sv
module breath_col_pick #(
   parameter int NCOL  = 3,
   parameter int IDX_W = 2
) (
   input  logic [NCOL-1:0]  cen_i,
   input  logic [IDX_W-1:0] cur_i,
   output logic [IDX_W-1:0] first_o,
   output logic [IDX_W-1:0] next_o,
   output logic             has_next_o
);
   always_comb begin
      first_o    = '0;
      next_o     = cur_i;
      has_next_o = 1'b0;
      for (int i = NCOL - 1; i >= 0; i--) begin
         if (cen_i[i]) first_o = IDX_W'(i);
         if (cen_i[i] && i > int'(cur_i)) begin
            next_o     = IDX_W'(i);
            has_next_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/breath_seq.sv
module breath_seq #(
   parameter int          LVL_W   = 8,
   parameter int          NCOL    = 3,
   parameter int          CREP_W  = 2,
   parameter int          PULSE_W = 4,
   parameter int          LOOP_W  = 8,
   parameter int unsigned TICK_US = 10000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_i,
   input  logic                     upd_we_i,
   input  logic [7:0]               upd_data_i,
   input  logic [23:0]              cfg_dur_i,
   input  logic [NCOL*LVL_W-1:0]    cfg_lvl_i,
   input  logic [NCOL-1:0]          cfg_cen_i,
   input  logic [NCOL*CREP_W-1:0]   cfg_crep_i,
   input  logic [PULSE_W-1:0]       cfg_pulses_i,
   input  logic [LOOP_W-1:0]        cfg_loops_i,
   input  logic                     cfg_hold_en_i,
   input  logic                     cfg_hold_on_i,
   input  logic [1:0]               cfg_next_i,
   output logic [LVL_W-1:0]         lvl_o,
   output logic [1:0]               ramp_o,
   output logic [2:0]               phase_o,
   output logic [7:0]               state_o,
   output logic                     chain_o,
   output logic [1:0]               chain_sel_o
);
   import breath_pkg::*;

   localparam int IDX_W  = (NCOL > 1) ? $clog2(NCOL) : 1;
   localparam int LCNT_W = LOOP_W - 1 + 4;
   localparam int DUR_W  = $clog2(code_ticks(4'hF, TICK_US) + 1);
   localparam int DUR_VW = NUM_PHASES * CODE_W;

   if (NCOL < 1 || NCOL > 3) begin : g_bad_ncol
      $error("breath_seq: NCOL must be 1..3");
   end
   if (LOOP_W < 2) begin : g_bad_loop
      $error("breath_seq: LOOP_W must be at least 2");
   end
   if (TICK_US < 1) begin : g_bad_tick
      $error("breath_seq: TICK_US must be positive");
   end
   if (LVL_W < 1 || CREP_W < 1 || PULSE_W < 1) begin : g_bad_w
      $error("breath_seq: field widths must be positive");
   end

   // working copies captured at start
   logic [DUR_VW-1:0]        w_dur;
   logic [NCOL*LVL_W-1:0]    w_lvl;
   logic [NCOL-1:0]          w_cen;
   logic [NCOL*CREP_W-1:0]   w_crep;
   logic [PULSE_W-1:0]       w_pulses;
   logic                     w_hold_en, w_hold_on;
   logic [1:0]               w_next;

   mode_e                    mode_q, mode_d;
   phase_e                   ph_q, ph_d;
   logic [IDX_W-1:0]         col_q, col_d;
   logic [DUR_W-1:0]         dcnt_q;
   logic                     chain_q;
   logic [1:0]               sel_q;

   logic                     go;
   logic                     phase_end;
   logic                     enter;
   logic                     fin;
   logic                     pul_ld, pul_dec, rep_ld, rep_dec, loop_dec;
   logic [CREP_W-1:0]        rep_val;
   logic [3:0]               sel_code;
   logic [DUR_W-1:0]         ticks_m1;
   logic [LCNT_W-1:0]        loop_val;

   logic [IDX_W-1:0]         col_first, col_next;
   logic                     col_has_next;
   logic [PULSE_W-1:0]       pul_cnt;
   logic [CREP_W-1:0]        rep_cnt;
   logic [LCNT_W-1:0]        loop_cnt;
   logic                     pul_last, rep_last, loop_last;
   logic                     final_pulse;
   logic [CREP_W-1:0]        crep_first, crep_next;

   assign go        = upd_we_i && (upd_data_i == START_KEY) && (|cfg_cen_i);
   assign phase_end = (mode_q == MD_RUN) && tick_i && (dcnt_q == '0);

   assign loop_val  = cfg_loops_i[LOOP_W-1]
                    ? {cfg_loops_i[LOOP_W-2:0], 4'b0000}
                    : {4'b0000, cfg_loops_i[LOOP_W-2:0]};

   assign crep_first = w_crep[int'(col_first)*CREP_W +: CREP_W];
   assign crep_next  = w_crep[int'(col_next)*CREP_W +: CREP_W];

   breath_col_pick #(.NCOL(NCOL), .IDX_W(IDX_W)) u_pick (
      .cen_i      (w_cen),
      .cur_i      (col_q),
      .first_o    (col_first),
      .next_o     (col_next),
      .has_next_o (col_has_next)
   );

   breath_loop_ctr #(.W(PULSE_W)) u_pul (
      .clk(clk), .rst_n(rst_n), .load_i(pul_ld), .load_val_i(w_pulses),
      .dec_i(pul_dec), .cnt_o(pul_cnt), .last_o(pul_last)
   );

   breath_loop_ctr #(.W(CREP_W)) u_rep (
      .clk(clk), .rst_n(rst_n), .load_i(rep_ld), .load_val_i(rep_val),
      .dec_i(rep_dec), .cnt_o(rep_cnt), .last_o(rep_last)
   );

   breath_loop_ctr #(.W(LCNT_W)) u_loop (
      .clk(clk), .rst_n(rst_n), .load_i(go), .load_val_i(loop_val),
      .dec_i(loop_dec), .cnt_o(loop_cnt), .last_o(loop_last)
   );

   assign final_pulse = pul_last && rep_last && !col_has_next && loop_last;

   // sequencing decision
   always_comb begin
      mode_d   = mode_q;
      ph_d     = ph_q;
      col_d    = col_q;
      enter    = 1'b0;
      fin      = 1'b0;
      pul_ld   = 1'b0;
      pul_dec  = 1'b0;
      rep_ld   = 1'b0;
      rep_dec  = 1'b0;
      loop_dec = 1'b0;
      rep_val  = crep_first;
      if (go) begin
         mode_d = MD_RUN;
         ph_d   = PH_START;
         enter  = 1'b1;
      end else if (phase_end) begin
         unique case (ph_q)
            PH_START: begin
               ph_d   = PH_RISE;
               col_d  = col_first;
               pul_ld = 1'b1;
               rep_ld = 1'b1;
               enter  = 1'b1;
            end
            PH_RISE: begin
               ph_d  = PH_HOLD;
               enter = 1'b1;
            end
            PH_HOLD: begin
               if (final_pulse && w_hold_en && w_hold_on) begin
                  mode_d = MD_PARK_LIT;
                  fin    = 1'b1;
               end else begin
                  ph_d  = PH_FALL;
                  enter = 1'b1;
               end
            end
            PH_FALL: begin
               enter = 1'b1;
               ph_d  = PH_GAP;
               if (!pul_last) begin
                  pul_dec = 1'b1;
               end else if (!rep_last) begin
                  pul_ld  = 1'b1;
                  rep_dec = 1'b1;
               end else if (col_has_next) begin
                  col_d   = col_next;
                  pul_ld  = 1'b1;
                  rep_ld  = 1'b1;
                  rep_val = crep_next;
               end else begin
                  ph_d = PH_OFF;
               end
            end
            PH_GAP: begin
               ph_d  = PH_RISE;
               enter = 1'b1;
            end
            PH_OFF: begin
               if (!loop_last) begin
                  ph_d     = PH_RISE;
                  col_d    = col_first;
                  pul_ld   = 1'b1;
                  rep_ld   = 1'b1;
                  loop_dec = 1'b1;
                  enter    = 1'b1;
               end else begin
                  fin = 1'b1;
                  if (w_hold_en && !w_hold_on) begin
                     mode_d = MD_PARK_DRK;
                  end else begin
                     mode_d = MD_IDLE;
                     ph_d   = PH_START;
                  end
               end
            end
            default: ph_d = PH_START;
         endcase
      end
   end

   assign sel_code = go ? cfg_dur_i[CODE_W-1:0] : w_dur[int'(ph_d)*CODE_W +: CODE_W];

   breath_dur_sel #(.TICK_US(TICK_US), .DUR_W(DUR_W)) u_dur (
      .code_i     (sel_code),
      .ticks_m1_o (ticks_m1)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MD_IDLE;
         ph_q   <= PH_START;
         col_q  <= '0;
         dcnt_q <= '0;
      end else begin
         mode_q <= mode_d;
         ph_q   <= ph_d;
         col_q  <= col_d;
         if (enter)
            dcnt_q <= ticks_m1;
         else if (mode_q == MD_RUN && tick_i && dcnt_q != '0)
            dcnt_q <= dcnt_q - DUR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_dur     <= '0;
         w_lvl     <= '0;
         w_cen     <= '0;
         w_crep    <= '0;
         w_pulses  <= '0;
         w_hold_en <= 1'b0;
         w_hold_on <= 1'b0;
         w_next    <= '0;
      end else if (go) begin
         w_dur     <= cfg_dur_i;
         w_lvl     <= cfg_lvl_i;
         w_cen     <= cfg_cen_i;
         w_crep    <= cfg_crep_i;
         w_pulses  <= cfg_pulses_i;
         w_hold_en <= cfg_hold_en_i;
         w_hold_on <= cfg_hold_on_i;
         w_next    <= cfg_next_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= 1'b0;
         sel_q   <= '0;
      end else begin
         chain_q <= fin && (w_next == 2'b01 || w_next == 2'b10);
         if (fin) sel_q <= w_next;
      end
   end

   // output decode
   logic       lit;
   logic       show_col;
   logic [2:0] col_bits;
   logic       running;

   assign running  = (mode_q == MD_RUN);
   assign lit      = (running && (ph_q == PH_RISE || ph_q == PH_HOLD || ph_q == PH_FALL))
                   || (mode_q == MD_PARK_LIT);
   assign show_col = (running && ph_q != PH_START) || (mode_q == MD_PARK_LIT);
   assign col_bits = show_col ? (3'b001 << col_q) : 3'b000;

   assign lvl_o       = lit ? w_lvl[int'(col_q)*LVL_W +: LVL_W] : '0;
   assign ramp_o      = {running && ph_q == PH_FALL, running && ph_q == PH_RISE};
   assign phase_o     = ph_q;
   assign state_o     = {running, col_bits, 1'b0, ph_q};
   assign chain_o     = chain_q;
   assign chain_sel_o = sel_q;
endmodule

// File: rtl/breath_seq_chk.sv
module breath_seq_chk #(
   parameter int LVL_W = 8,
   parameter int NCOL  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             upd_we_i,
   input logic [7:0]       upd_data_i,
   input logic [NCOL-1:0]  cfg_cen_i,
   input logic [LVL_W-1:0] lvl_o,
   input logic [1:0]       ramp_o,
   input logic [2:0]       phase_o,
   input logic [7:0]       state_o,
   input logic             chain_o
);
   logic key, go;
   assign key = upd_we_i && (upd_data_i == 8'hC5);
   assign go  = key && (|cfg_cen_i);

   // R3
   phase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= 3'd5);

   // R1
   start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (state_o[7] && phase_o == 3'd0));

   // R1
   no_colour_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key && cfg_cen_i == '0 && !state_o[7]) |=> !state_o[7]);

   // R3
   phase_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o[7] && $past(state_o[7]) && !$past(go) && phase_o != $past(phase_o)) |->
         (($past(phase_o) == 3'd0 && phase_o == 3'd1) ||
          ($past(phase_o) == 3'd1 && phase_o == 3'd2) ||
          ($past(phase_o) == 3'd2 && phase_o == 3'd3) ||
          ($past(phase_o) == 3'd3 && phase_o == 3'd4) ||
          ($past(phase_o) == 3'd3 && phase_o == 3'd5) ||
          ($past(phase_o) == 3'd4 && phase_o == 3'd1) ||
          ($past(phase_o) == 3'd5 && phase_o == 3'd1)));

   // R2
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o[7] && $past(state_o[7]) && !$past(tick_i) && !$past(go)) |-> $stable(phase_o));

   // R7
   dark_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o[7] && (phase_o == 3'd0 || phase_o == 3'd4 || phase_o == 3'd5)) |-> lvl_o == '0);

   // R7
   ramp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ramp_o) && $onehot0(state_o[6:4]));

   // R8
   park_lit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!state_o[7] && $past(!state_o[7]) && phase_o == 3'd2 && !$past(go)) |-> $stable(lvl_o));

   // R9
   chain_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chain_o |=> !chain_o);

   // R9
   chain_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chain_o |-> !state_o[7]);
endmodule

bind breath_seq breath_seq_chk #(.LVL_W(LVL_W), .NCOL(NCOL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .upd_we_i   (upd_we_i),
   .upd_data_i (upd_data_i),
   .cfg_cen_i  (cfg_cen_i),
   .lvl_o      (lvl_o),
   .ramp_o     (ramp_o),
   .phase_o    (phase_o),
   .state_o    (state_o),
   .chain_o    (chain_o)
);

// File: tb/tb_breath_seq.sv
module tb_breath_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        upd_we_i = 1'b0;
   logic [7:0]  upd_data_i = 8'h00;
   logic [23:0] cfg_dur_i = '0;
   logic [23:0] cfg_lvl_i = '0;
   logic [2:0]  cfg_cen_i = '0;
   logic [5:0]  cfg_crep_i = '0;
   logic [3:0]  cfg_pulses_i = '0;
   logic [7:0]  cfg_loops_i = '0;
   logic        cfg_hold_en_i = 1'b0;
   logic        cfg_hold_on_i = 1'b0;
   logic [1:0]  cfg_next_i = '0;
   logic [7:0]  lvl_o;
   logic [1:0]  ramp_o;
   logic [2:0]  phase_o;
   logic [7:0]  state_o;
   logic        chain_o;
   logic [1:0]  chain_sel_o;

   breath_seq dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .upd_we_i(upd_we_i), .upd_data_i(upd_data_i),
      .cfg_dur_i(cfg_dur_i), .cfg_lvl_i(cfg_lvl_i), .cfg_cen_i(cfg_cen_i), .cfg_crep_i(cfg_crep_i),
      .cfg_pulses_i(cfg_pulses_i), .cfg_loops_i(cfg_loops_i), .cfg_hold_en_i(cfg_hold_en_i),
      .cfg_hold_on_i(cfg_hold_on_i), .cfg_next_i(cfg_next_i), .lvl_o(lvl_o), .ramp_o(ramp_o),
      .phase_o(phase_o), .state_o(state_o), .chain_o(chain_o), .chain_sel_o(chain_sel_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    ended = 0;
   string cur_req = "R7";
   int    tick_style = 0;
   int    cyc = 0;

   // ---------------- reference model ----------------
   int m_mode, m_ph, m_rem, m_col, m_pul, m_rep, m_loop, m_chain, m_sel;
   int w_dur[6];
   int w_lvl[3];
   int w_crep[3];
   bit w_cen[3];
   int w_pulses, w_next;
   bit w_hold_en, w_hold_on;

   function automatic int cs_of(int c);
      int tab[16] = '{3, 13, 26, 38, 51, 77, 104, 160, 210, 260, 310, 420, 520, 620, 730, 830};
      return tab[c];
   endfunction

   function automatic int first_en();
      for (int i = 0; i < 3; i++) if (w_cen[i]) return i;
      return 0;
   endfunction

   function automatic int next_en(int c);
      for (int i = c + 1; i < 3; i++) if (w_cen[i]) return i;
      return -1;
   endfunction

   function automatic int dec_cnt(int v);
      return (v > 1) ? v - 1 : v;
   endfunction

   task automatic m_enter(int p);
      m_ph  = p;
      m_rem = cs_of(w_dur[p]);
   endtask

   task automatic m_finish();
      m_sel   = w_next;
      m_chain = (w_next == 1 || w_next == 2) ? 1 : 0;
   endtask

   task automatic m_advance();
      int nx;
      case (m_ph)
         0: begin m_col = first_en(); m_pul = w_pulses; m_rep = w_crep[m_col]; m_enter(1); end
         1: m_enter(2);
         2: begin
            if (m_pul == 1 && m_rep == 1 && next_en(m_col) < 0 && m_loop == 1 && w_hold_en && w_hold_on) begin
               m_mode = 2; m_finish();
            end else m_enter(3);
         end
         3: begin
            nx = next_en(m_col);
            if (m_pul != 1) begin m_pul = dec_cnt(m_pul); m_enter(4); end
            else if (m_rep != 1) begin m_rep = dec_cnt(m_rep); m_pul = w_pulses; m_enter(4); end
            else if (nx >= 0) begin m_col = nx; m_pul = w_pulses; m_rep = w_crep[nx]; m_enter(4); end
            else m_enter(5);
         end
         4: m_enter(1);
         default: begin
            if (m_loop != 1) begin
               m_loop = dec_cnt(m_loop); m_col = first_en(); m_pul = w_pulses; m_rep = w_crep[m_col];
               m_enter(1);
            end else begin
               m_finish();
               if (w_hold_en && !w_hold_on) m_mode = 3;
               else begin m_mode = 0; m_ph = 0; end
            end
         end
      endcase
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_mode = 0; m_ph = 0; m_rem = 0; m_col = 0; m_pul = 0; m_rep = 0; m_loop = 0;
         m_chain = 0; m_sel = 0;
         for (int i = 0; i < 6; i++) w_dur[i] = 0;
         for (int i = 0; i < 3; i++) begin w_lvl[i] = 0; w_crep[i] = 0; w_cen[i] = 0; end
         w_pulses = 0; w_next = 0; w_hold_en = 0; w_hold_on = 0;
      end else begin
         m_chain = 0;
         if (upd_we_i && upd_data_i == 8'hC5 && cfg_cen_i != 0) begin
            for (int i = 0; i < 6; i++) w_dur[i] = int'(cfg_dur_i[i*4 +: 4]);
            for (int i = 0; i < 3; i++) begin
               w_lvl[i]  = int'(cfg_lvl_i[i*8 +: 8]);
               w_crep[i] = int'(cfg_crep_i[i*2 +: 2]);
               w_cen[i]  = cfg_cen_i[i];
            end
            w_pulses = int'(cfg_pulses_i); w_next = int'(cfg_next_i);
            w_hold_en = cfg_hold_en_i; w_hold_on = cfg_hold_on_i;
            m_loop = int'(cfg_loops_i[6:0]) * (cfg_loops_i[7] ? 16 : 1);
            m_mode = 1;
            m_enter(0);
         end else if (m_mode == 1 && tick_i) begin
            if (m_rem > 1) m_rem--;
            else m_advance();
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   int  chain_cnt, last_sel, rise_cnt, ts_len;
   bit  col2_seen;
   logic [1:0] prev_ramp = 2'b00;

   always @(negedge clk) begin
      int e_lvl, e_ramp, e_state;
      bit lit, showc;
      #1;
      if (rst_n && !ended) begin
         lit    = (m_mode == 1 && m_ph >= 1 && m_ph <= 3) || m_mode == 2;
         showc  = (m_mode == 1 && m_ph != 0) || m_mode == 2;
         e_lvl  = lit ? w_lvl[m_col] : 0;
         e_ramp = (m_mode == 1 && m_ph == 1) ? 1 : ((m_mode == 1 && m_ph == 3) ? 2 : 0);
         e_state = ((m_mode == 1) ? 128 : 0) | (showc ? ((1 << m_col) << 4) : 0) | m_ph;
         chk(cur_req, "lvl_o", int'(lvl_o), e_lvl);
         chk(cur_req, "ramp_o", int'(ramp_o), e_ramp);
         chk(cur_req, "state_o", int'(state_o), e_state);
         chk(cur_req, "phase_o", int'(phase_o), m_ph);
         chk("R9", "chain_o", int'(chain_o), m_chain);
         if (m_chain != 0) chk("R9", "chain_sel_o", int'(chain_sel_o), m_sel);
         if (chain_o) begin chain_cnt++; last_sel = int'(chain_sel_o); end
         if (ramp_o == 2'b01 && prev_ramp != 2'b01) rise_cnt++;
         if (state_o[7] && phase_o == 3'd0) ts_len++;
         if (state_o[5]) col2_seen = 1;
         prev_ramp = ramp_o;
      end
   end

   always @(negedge clk) tick_i <= (tick_style == 0) ? 1'b1 : ((cyc % 3) != 1);

   // ---------------- stimulus helpers ----------------
   task automatic write_key(logic [7:0] v);
      @(negedge clk); upd_we_i = 1'b1; upd_data_i = v;
      @(negedge clk); upd_we_i = 1'b0; upd_data_i = 8'h00;
   endtask

   task automatic wait_done(int cap);
      int k = 0;
      while (m_mode == 1 && k < cap) begin @(negedge clk); k++; end
      repeat (3) @(negedge clk);
   endtask

   task automatic clr_obs();
      chain_cnt = 0; last_sel = -1; rise_cnt = 0; ts_len = 0; col2_seen = 0;
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R7)
      chk("R7", "reset state_o", int'(state_o), 0);
      chk("R7", "reset lvl_o", int'(lvl_o), 0);

      // R1: key with no colour, then wrong key value
      cur_req = "R1";
      cfg_dur_i = '0; cfg_lvl_i = 24'h00_00_55; cfg_cen_i = 3'b000; cfg_crep_i = 6'b00_00_01;
      cfg_pulses_i = 4'd1; cfg_loops_i = 8'd1;
      write_key(8'hC5);
      repeat (3) @(negedge clk);
      chk("R1", "no colour run bit", int'(state_o[7]), 0);
      cfg_cen_i = 3'b001;
      write_key(8'hC4);
      repeat (3) @(negedge clk);
      chk("R1", "wrong key run bit", int'(state_o[7]), 0);

      // R2 R3 R4: two pulses, one colour, chain to 01
      cur_req = "R4"; clr_obs();
      cfg_dur_i = {4'd0, 4'd1, 4'd0, 4'd2, 4'd0, 4'd1};
      cfg_pulses_i = 4'd2; cfg_next_i = 2'b01; cfg_hold_en_i = 1'b0;
      write_key(8'hC5);
      wait_done(5000);
      chk("R4", "pulses seen", rise_cnt, 2);
      chk("R9", "chain pulses", chain_cnt, 1);
      chk("R9", "chain select", last_sel, 1);
      chk("R8", "idle phase", int'(phase_o), 0);

      // R5 R8: three colours, repeats 1/2/1, two loops, park lit
      cur_req = "R5"; clr_obs();
      cfg_dur_i = '0; cfg_lvl_i = 24'hFF_80_40; cfg_cen_i = 3'b111;
      cfg_crep_i = {2'b01, 2'b10, 2'b01}; cfg_pulses_i = 4'd1; cfg_loops_i = 8'd2;
      cfg_hold_en_i = 1'b1; cfg_hold_on_i = 1'b1; cfg_next_i = 2'b00;
      write_key(8'hC5);
      wait_done(5000);
      chk("R5", "pulses over two loops", rise_cnt, 8);
      chk("R8", "parked lit level", int'(lvl_o), 8'hFF);
      chk("R8", "parked lit phase", int'(phase_o), 2);
      chk("R9", "no chain for 00", chain_cnt, 0);

      // R5 R8 R2: colours 1 and 3, park dark, irregular ticks, chain 10
      cur_req = "R8"; clr_obs(); tick_style = 1;
      cfg_dur_i = {4'd1, 4'd0, 4'd1, 4'd0, 4'd1, 4'd0};
      cfg_cen_i = 3'b101; cfg_crep_i = 6'b01_01_01; cfg_loops_i = 8'd1;
      cfg_hold_on_i = 1'b0; cfg_next_i = 2'b10;
      write_key(8'hC5);
      wait_done(5000);
      chk("R5", "colour 2 skipped", int'(col2_seen), 0);
      chk("R8", "parked dark phase", int'(phase_o), 5);
      chk("R8", "parked dark level", int'(lvl_o), 0);
      chk("R9", "chain select 10", last_sel, 2);
      tick_style = 0;

      // R6: loop field 0x81 gives 16 loops
      cur_req = "R6"; clr_obs();
      cfg_dur_i = '0; cfg_cen_i = 3'b010; cfg_loops_i = 8'h81; cfg_hold_en_i = 1'b0; cfg_next_i = 2'b11;
      write_key(8'hC5);
      wait_done(5000);
      chk("R6", "loops x16", rise_cnt, 16);
      chk("R9", "no chain for 11", chain_cnt, 0);

      // R4 endless pulses, R10 ignored changes and restart
      cur_req = "R10"; clr_obs();
      cfg_cen_i = 3'b001; cfg_pulses_i = 4'd0; cfg_loops_i = 8'd1;
      write_key(8'hC5);
      repeat (150) @(negedge clk);
      cfg_lvl_i = 24'h12_34_99; cfg_dur_i = {6{4'd1}}; cfg_pulses_i = 4'd1;
      repeat (150) @(negedge clk);
      chk("R4", "endless still running", int'(state_o[7]), 1);
      write_key(8'hC5);
      chk("R10", "restart phase", int'(phase_o), 0);
      chk("R10", "restart run", int'(state_o[7]), 1);
      wait_done(5000);

      // R2: longest code on the start phase
      cur_req = "R2"; clr_obs();
      cfg_dur_i = {5'd0, 4'd0, 15'd0} | 24'h00000F;
      write_key(8'hC5);
      wait_done(10000);
      chk("R2", "start length code 15", ts_len, 830);

      // R5 endless colour repeat, then reset
      cur_req = "R5"; clr_obs();
      cfg_dur_i = '0; cfg_cen_i = 3'b011; cfg_crep_i = 6'b01_01_00;
      write_key(8'hC5);
      repeat (300) @(negedge clk);
      chk("R5", "endless colour holds", int'(col2_seen), 0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7", "after reset state", int'(state_o), 0);
      chk("R7", "after reset level", int'(lvl_o), 0);
      repeat (3) @(negedge clk);
      summary();
   end
endmodule